// File: doc/BRIEF.md
# Flash Range Protection Checker

This block sits in front of a serial flash command engine. It decides whether each outgoing command may reach the flash. For every request it compares the target address with a small set of protection windows. For some requests it also compares the opcode with a list of restricted opcodes. It then answers with a grant or a deny in the same cycle. Any denial also sets a sticky violation flag, which stays set until it is cleared explicitly.

Each window covers exactly one granule, either 4 KiB or 64 KiB, chosen per window. The window start is a granule index. A region larger than one granule takes several windows with consecutive indices. Each window carries its own read-protect and write-protect enables. Read protection refuses every read-class request that lands in the window. Write protection refuses only the opcodes held in the restricted-opcode registers. Those registers accept one write after reset, so a boot stage can fix the opcode list and later code cannot loosen it.

Top module: `fprot_guard`

## Requirements
- R1: After reset every window register and restricted-opcode register reads as zero, the restricted-opcode registers are unlocked, `viol_sticky` is 0, and every valid request is granted.
- R2: A write to select 0..3 loads window register 0..3. Its bit fields are [7:0] granule index, bit 8 size (1 = 64 KiB, 0 = 4 KiB), bit 9 write-protect and bit 10 read-protect. A window whose register is all zeros never matches.
- R3: A 4 KiB window with index N matches addresses N*4096 through N*4096+4095 only. Addresses of 1 MiB and above never match a 4 KiB window.
- R4: A 64 KiB window with index N matches addresses N*65536 through N*65536+65535.
- R5: A request with `req_is_read`=1 that matches a read-protected window is denied, whatever its opcode.
- R6: A request that matches a write-protected window is denied only if its opcode equals a nonzero byte of a restricted-opcode register. Unlisted opcodes are granted, and a zero byte lists nothing.
- R7: Selects 4 and 5 load the two restricted-opcode registers, each holding four opcode bytes. The erase opcode slot is bits 15:8 of select 4. Each register takes its first write after reset and ignores every later write.
- R8: With `req_valid`=1, exactly one of `grant` and `deny` is high in the same cycle as the request, with no register in the path. With `req_valid`=0 both are low.
- R9: `viol_sticky` rises on the clock edge after a cycle with `deny`=1 and holds until a write to select 6 with data bit 0 = 1. If a denial happens in the same cycle as that write, the flag stays set.
- R10: Windows are checked independently. A region made of windows with consecutive indices protects every address across all of its granules, and the addresses just outside it are granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Register select: 0..3 windows, 4..5 opcode lists, 6 flag clear |
| cfg_wr_data | input | 32 | Register write data |
| req_valid | input | 1 | Command request present |
| req_opc | input | 8 | Command opcode |
| req_addr | input | 24 | Command target offset |
| req_is_read | input | 1 | Request is read class |
| grant | output | 1 | Command may proceed |
| deny | output | 1 | Command refused |
| viol_sticky | output | 1 | A command has been refused since the last clear |

## Verification
Four properties hold on every cycle. A locked opcode register never changes under a write. A denial is always followed by the sticky flag. The flag never drops without a clear write. A window just loaded with zero never reports a match. Only the bench's scenarios can show the address arithmetic. They cover granule edges at both sizes, aliasing above 1 MiB, the split between read and write protection, and that a rejected rewrite of the opcode list leaves the old opcodes in force. Only the scenarios show that a denial wins over a clear in the same cycle.

// File: rtl/fprot_pkg.sv
package fprot_pkg;
   localparam int IDX_W  = 8;
   localparam int CFG_W  = 11;
   localparam int OPC_W  = 8;

   typedef struct packed {
      logic             rd_prot;
      logic             wr_prot;
      logic             big_unit;
      logic [IDX_W-1:0] idx;
   } win_cfg_t;
endpackage

// File: rtl/fprot_range_unit.sv
module fprot_range_unit #(
   parameter int ADDR_W      = 24,
   parameter int SMALL_SHIFT = 12,
   parameter int LARGE_SHIFT = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [fprot_pkg::CFG_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]          addr,
   output logic                       hit,
   output logic                       wp,
   output logic                       rp
);
   import fprot_pkg::*;

   localparam int SPAN_S = ADDR_W - SMALL_SHIFT;
   localparam int SPAN_L = ADDR_W - LARGE_SHIFT;

   generate
      if (SMALL_SHIFT >= LARGE_SHIFT) begin : g_bad_shift
         $error("SMALL_SHIFT must be below LARGE_SHIFT");
      end
      if (SPAN_L < 1) begin : g_bad_addr
         $error("ADDR_W must exceed LARGE_SHIFT");
      end
   endgenerate

   win_cfg_t cfg_q;
   logic     in_use;
   logic     small_hit;
   logic     large_hit;
   logic [SPAN_S-1:0] top_s;
   logic [SPAN_L-1:0] top_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cfg_q <= '0;
      else if (wr_en) cfg_q <= win_cfg_t'(wr_data);
   end

   assign in_use = |cfg_q;
   assign top_s  = addr[ADDR_W-1:SMALL_SHIFT];
   assign top_l  = addr[ADDR_W-1:LARGE_SHIFT];

   generate
      if (SPAN_S >= IDX_W) begin : g_small_wide
         assign small_hit = (top_s == SPAN_S'(cfg_q.idx));
      end else begin : g_small_narrow
         assign small_hit = (IDX_W'(top_s) == cfg_q.idx);
      end
      if (SPAN_L >= IDX_W) begin : g_large_wide
         assign large_hit = (top_l == SPAN_L'(cfg_q.idx));
      end else begin : g_large_narrow
         assign large_hit = (IDX_W'(top_l) == cfg_q.idx);
      end
   endgenerate

   assign hit = in_use && (cfg_q.big_unit ? large_hit : small_hit);
   assign wp  = cfg_q.wr_prot;
   assign rp  = cfg_q.rd_prot;
endmodule

// File: rtl/fprot_opc_lock.sv
module fprot_opc_lock #(
   parameter int SLOTS = 4,
   parameter int OPC_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [SLOTS*OPC_W-1:0] wr_data,
   input  logic [OPC_W-1:0]       opc,
   output logic                   listed
);
   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("SLOTS must be at least 1");
      end
   endgenerate

   logic [SLOTS*OPC_W-1:0] val_q;
   logic                   locked_q;
   logic [SLOTS-1:0]       slot_eq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         val_q    <= '0;
         locked_q <= 1'b0;
      end else if (wr_en && !locked_q) begin
         val_q    <= wr_data;
         locked_q <= 1'b1;
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [OPC_W-1:0] entry;
      assign entry      = val_q[s*OPC_W +: OPC_W];
      assign slot_eq[s] = (entry != '0) && (entry == opc);
   end

   assign listed = |slot_eq;

   // R7
   write_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_q && wr_en) |=> $stable(val_q));
endmodule

// File: rtl/fprot_guard.sv
module fprot_guard #(
   parameter int NUM_WIN      = 4,
   parameter int NUM_CMD_REGS = 2,
   parameter int OPC_SLOTS    = 4,
   parameter int ADDR_W       = 24,
   parameter int SEL_W        = 3,
   parameter int DATA_W       = 32,
   parameter int SMALL_SHIFT  = 12,
   parameter int LARGE_SHIFT  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr_en,
   input  logic [SEL_W-1:0]    cfg_wr_sel,
   input  logic [DATA_W-1:0]   cfg_wr_data,
   input  logic                req_valid,
   input  logic [7:0]          req_opc,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic                req_is_read,
   output logic                grant,
   output logic                deny,
   output logic                viol_sticky
);
   import fprot_pkg::*;

   localparam int CMD_BASE  = NUM_WIN;
   localparam int CLR_SEL   = NUM_WIN + NUM_CMD_REGS;
   localparam int LIST_W    = OPC_SLOTS * OPC_W;

   generate
      if (CLR_SEL >= (1 << SEL_W)) begin : g_bad_sel
         $error("SEL_W too narrow for the register map");
      end
      if (LIST_W > DATA_W || CFG_W > DATA_W) begin : g_bad_data
         $error("DATA_W too narrow for the register contents");
      end
   endgenerate

   logic [NUM_WIN-1:0]      win_hit;
   logic [NUM_WIN-1:0]      win_wp;
   logic [NUM_WIN-1:0]      win_rp;
   logic [NUM_CMD_REGS-1:0] cmd_listed;
   logic                    opc_restricted;
   logic                    rd_block;
   logic                    wr_block;
   logic                    clr_req;

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      fprot_range_unit #(
         .ADDR_W      (ADDR_W),
         .SMALL_SHIFT (SMALL_SHIFT),
         .LARGE_SHIFT (LARGE_SHIFT)
      ) range_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_wr_en && (cfg_wr_sel == SEL_W'(w))),
         .wr_data (cfg_wr_data[CFG_W-1:0]),
         .addr    (req_addr),
         .hit     (win_hit[w]),
         .wp      (win_wp[w]),
         .rp      (win_rp[w])
      );

      // R2
      unused_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wr_en && (cfg_wr_sel == SEL_W'(w)) && (cfg_wr_data[CFG_W-1:0] == '0))
         |=> !win_hit[w]);
   end

   for (genvar c = 0; c < NUM_CMD_REGS; c++) begin : g_cmd
      fprot_opc_lock #(
         .SLOTS (OPC_SLOTS),
         .OPC_W (OPC_W)
      ) lock_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (cfg_wr_en && (cfg_wr_sel == SEL_W'(CMD_BASE + c))),
         .wr_data (cfg_wr_data[LIST_W-1:0]),
         .opc     (req_opc),
         .listed  (cmd_listed[c])
      );
   end

   assign opc_restricted = |cmd_listed;
   assign rd_block = req_is_read && |(win_hit & win_rp);
   assign wr_block = opc_restricted && |(win_hit & win_wp);
   assign deny     = req_valid && (rd_block || wr_block);
   assign grant    = req_valid && !deny;
   assign clr_req  = cfg_wr_en && (cfg_wr_sel == SEL_W'(CLR_SEL)) && cfg_wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       viol_sticky <= 1'b0;
      else if (deny)    viol_sticky <= 1'b1;
      else if (clr_req) viol_sticky <= 1'b0;
   end

   // R9
   deny_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deny |=> viol_sticky);

   // R9
   flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_sticky && !clr_req) |=> viol_sticky);

   // R8
   one_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, deny}));
endmodule

// File: tb/fprot_guard_tb_top.sv
module fprot_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr_en = 1'b0;
   logic [2:0]  cfg_wr_sel = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        req_valid = 1'b0;
   logic [7:0]  req_opc = '0;
   logic [23:0] req_addr = '0;
   logic        req_is_read = 1'b0;
   logic        grant, deny, viol_sticky;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   fprot_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
      .cfg_wr_data(cfg_wr_data), .req_valid(req_valid), .req_opc(req_opc),
      .req_addr(req_addr), .req_is_read(req_is_read), .grant(grant),
      .deny(deny), .viol_sticky(viol_sticky)
   );

   // entry: {tag[3:0], opc[7:0], addr[23:0], is_read, expect_deny}
   localparam logic [37:0] VEC [13] = '{
      {4'd3,  8'h02, 24'h005000, 1'b0, 1'b1},  // R3 first byte of window
      {4'd3,  8'h02, 24'h005FFF, 1'b0, 1'b1},  // R3 last byte
      {4'd3,  8'h02, 24'h004FFF, 1'b0, 1'b0},  // R3 just below
      {4'd10, 8'h02, 24'h007000, 1'b0, 1'b0},  // R10 just past region
      {4'd10, 8'hD8, 24'h006800, 1'b0, 1'b1},  // R10 second granule, erase
      {4'd6,  8'h03, 24'h005000, 1'b1, 1'b0},  // R6 read passes write window
      {4'd6,  8'h20, 24'h005000, 1'b0, 1'b0},  // R6 unlisted opcode
      {4'd4,  8'h03, 24'h030000, 1'b1, 1'b1},  // R4 64K start
      {4'd5,  8'h0B, 24'h03FFFF, 1'b1, 1'b1},  // R5 64K end, any opcode
      {4'd4,  8'h03, 24'h040000, 1'b1, 1'b0},  // R4 past 64K window
      {4'd5,  8'h02, 24'h030000, 1'b0, 1'b0},  // R5 write into read-only window
      {4'd3,  8'h02, 24'h105000, 1'b0, 1'b0},  // R3 alias above 1 MiB
      {4'd2,  8'h02, 24'h000000, 1'b0, 1'b0}   // R2 zero register unused
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [31:0] data);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
      @(negedge clk);
      cfg_wr_en = 1'b0;
   endtask

   task automatic issue(input logic [7:0] opc, input logic [23:0] addr, input logic rd);
      @(negedge clk);
      req_valid = 1'b1; req_opc = opc; req_addr = addr; req_is_read = rd;
      #2;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      issue(8'h02, 24'h005000, 1'b0);
      check("R1 grant", grant, 1);
      check("R1 deny", deny, 0);
      check("R1 sticky", viol_sticky, 0);
      // R8 idle
      @(negedge clk); req_valid = 1'b0; #2;
      check("R8 idle", {grant, deny}, 0);

      wr_reg(3'd0, 32'h0000_0205);   // 4K idx 5 write-protect
      wr_reg(3'd1, 32'h0000_0206);   // 4K idx 6 write-protect
      wr_reg(3'd2, 32'h0000_0503);   // 64K idx 3 read-protect
      wr_reg(3'd4, 32'h0000_D802);   // program + erase
      for (int i = 0; i < 13; i++) begin
         issue(VEC[i][33:26], VEC[i][25:2], VEC[i][1]);
         check($sformatf("R%0d vec%0d deny", VEC[i][37:34], i), deny, VEC[i][0]);
         check($sformatf("R%0d vec%0d grant (R8)", VEC[i][37:34], i), grant, !VEC[i][0]);
      end

      // R9 clear, set, set-wins-over-clear
      @(negedge clk); req_valid = 1'b0;
      wr_reg(3'd6, 32'h1); #2;
      check("R9 cleared", viol_sticky, 0);
      issue(8'h02, 24'h005100, 1'b0);
      check("R9 not yet", viol_sticky, 0);
      @(negedge clk); req_valid = 1'b0; #2;
      check("R9 set", viol_sticky, 1);
      @(negedge clk);
      req_valid = 1'b1; cfg_wr_en = 1'b1; cfg_wr_sel = 3'd6; cfg_wr_data = 32'h1;
      @(negedge clk);
      req_valid = 1'b0; cfg_wr_en = 1'b0; #2;
      check("R9 set wins", viol_sticky, 1);
      wr_reg(3'd6, 32'h0); #2;
      check("R9 bit0 zero keeps", viol_sticky, 1);
      wr_reg(3'd6, 32'h1); #2;
      check("R9 cleared again", viol_sticky, 0);

      // R7 write-once
      wr_reg(3'd5, 32'h0000_0020);
      issue(8'h20, 24'h005000, 1'b0);
      check("R7 first write takes", deny, 1);
      wr_reg(3'd5, 32'h0000_0060);
      issue(8'h60, 24'h005000, 1'b0);
      check("R7 rewrite ignored new", deny, 0);
      issue(8'h20, 24'h005000, 1'b0);
      check("R7 rewrite ignored old", deny, 1);
      wr_reg(3'd4, 32'h0);
      issue(8'hD8, 24'h006000, 1'b0);
      check("R7 erase slot locked", deny, 1);

      // R2 window cleared to zero stops matching
      wr_reg(3'd0, 32'h0);
      issue(8'h02, 24'h005000, 1'b0);
      check("R2 cleared window", deny, 0);
      @(negedge clk); req_valid = 1'b0;
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_checks++; n_errors++;
         $display("FAIL watchdog actual=hung expected=done");
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule